// File: doc/BRIEF.md
# Double-Edge Strobe Burst Transmitter

This block is the sending side of a source-synchronous, 16-bit data-in burst. Words arrive from a local valid/ready stream. Each one is placed on a parallel data bus and then latched at the receiver by a single transition of a strobe line. Both the falling and the rising transition carry a word. The far end controls the burst with two plain inputs: a ready line, which permits strobe transitions while it is high, and a stop line, which holds the burst while it is high. The first transition of a burst is always a falling one.

All timing limits are integer clock-cycle parameters, each at least 1:
- the data setup time before a strobe transition;
- the hold time after a transition, before the bus may change again;
- the minimum spacing between any two transitions;
- the minimum spacing between two transitions of the same polarity;
- the start latency.

The block pauses by producing no transitions. This happens when the far end withdraws permission or when the local stream has no word to send. The strobe level is kept during a pause, and the next transition resumes the burst.

The input stream obeys these back-pressure rules:
- `in_ready` is high only when the bus is free, meaning the previous word has been strobed and its hold time has elapsed.
- `in_ready` never depends on `in_valid`.
- A word moves only in a cycle where both `in_valid` and `in_ready` are high.
- `in_data` is ignored when `in_valid` is low.

Top module: `sbt_burst_tx`

## Requirements
- R1: After reset the strobe is high, the data bus is 0, the word count is 0 and `in_ready` is high.
- R2: No strobe transition occurs in a cycle where `host_rdy` is low or `host_stop` is high, and the strobe keeps its level through such a pause.
- R3: A word is on the bus before the first strobe transition, and that first transition is falling (1 to 0).
- R4: Every strobe transition comes at least T_SETUP cycles after the bus last changed.
- R5: Any two successive strobe transitions are at least T_CYC cycles apart.
- R6: Two transitions of the same polarity are at least T_PAIR cycles apart (T_PAIR is at least 2*T_CYC).
- R7: The bus does not change for at least T_HOLD cycles after a transition, and `in_ready` stays low during that time.
- R8: Each transition transfers exactly one word. The bus value at each transition equals the next accepted stream word, in order. `word_count` rises by exactly one per transition.
- R9: A stream word is accepted only when `in_valid` and `in_ready` are both high, and it appears on the bus on the next cycle. `in_data` has no effect while `in_valid` is low.
- R10: When a word has met its setup time and the far end grants permission (ready high, stop low), the first transition occurs on the next clock edge, within T_START cycles.
- R11: When the stream runs dry the block produces no transition. It resumes with the next transition, of opposite polarity to the last one, once a word arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | DATA_W | Stream word |
| in_valid | input | 1 | Stream word present |
| in_ready | output | 1 | Block can take a word this cycle |
| host_rdy | input | 1 | Far end permits transitions |
| host_stop | input | 1 | Far end holds the burst |
| bus_data | output | DATA_W | Parallel data bus |
| bus_strobe | output | 1 | Strobe line, idle high |
| word_count | output | CNT_W | Words transferred since reset |

## Verification
The hardest condition to create is one where the same-polarity spacing, and not the single-edge spacing or the setup time, is the limit that decides when a transition happens. The bench chooses T_PAIR larger than 2*T_CYC and T_SETUP large enough that back-to-back words give gaps that alternate between 3 and 4 cycles. The stream and the far end also have to pause at specific moments. To get this, a back-to-back burst runs in parallel with a process that withdraws ready and then raises stop in the middle of the burst. A later run inserts gaps of varying length into the stream, so that the block starves with the strobe at both levels.

// File: rtl/sbt_pkg.sv
package sbt_pkg;
  typedef enum logic {
    STB_LOW  = 1'b0,
    STB_HIGH = 1'b1
  } stb_level_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned cnt_width(input int unsigned sat);
    return (sat < 2) ? 1 : $clog2(sat + 1);
  endfunction
endpackage

// File: rtl/sbt_since_cnt.sv
module sbt_since_cnt #(
  parameter int unsigned SAT = 4,
  parameter int unsigned W   = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  output logic [W-1:0] value
);
  // Cycles elapsed since the last restart, as seen before the next edge.
  always_ff @(posedge clk) begin
    if (!rst_n)                 value <= W'(SAT);
    else if (restart)           value <= W'(1);
    else if (value != W'(SAT))  value <= value + 1'b1;
  end
endmodule

// File: rtl/sbt_word_stage.sv
module sbt_word_stage #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned T_SETUP = 2,
  parameter int unsigned SAT     = 4,
  parameter int unsigned W       = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              hold_ok,
  input  logic              fire,
  output logic [DATA_W-1:0] bus_data,
  output logic              setup_ok
);
  logic         loaded_q;
  logic         take;
  logic [W-1:0] age;

  assign in_ready = !loaded_q && hold_ok;
  assign take     = in_ready && in_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loaded_q <= 1'b0;
      bus_data <= '0;
    end else if (take) begin
      loaded_q <= 1'b1;
      bus_data <= in_data;
    end else if (fire) begin
      loaded_q <= 1'b0;
    end
  end

  sbt_since_cnt #(.SAT(SAT), .W(W)) u_age (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (take),
    .value   (age)
  );

  assign setup_ok = loaded_q && (age >= W'(T_SETUP));
endmodule

// File: rtl/sbt_edge_pacer.sv
module sbt_edge_pacer
  import sbt_pkg::*;
#(
  parameter int unsigned T_CYC  = 2,
  parameter int unsigned T_PAIR = 4,
  parameter int unsigned T_HOLD = 1,
  parameter int unsigned SAT    = 4,
  parameter int unsigned W      = 3,
  parameter int unsigned CNT_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  output logic             space_ok,
  output logic             hold_ok,
  output logic             bus_strobe,
  output logic [CNT_W-1:0] word_count
);
  logic [W-1:0] since_last;
  logic [W-1:0] since_prev;
  stb_level_e   level_q;

  sbt_since_cnt #(.SAT(SAT), .W(W)) u_last (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (fire),
    .value   (since_last)
  );

  // Distance to the edge before the last one: same polarity as the next edge.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_prev <= W'(SAT);
    end else if (fire) begin
      since_prev <= (since_last == W'(SAT)) ? W'(SAT) : since_last + 1'b1;
    end else if (since_prev != W'(SAT)) begin
      since_prev <= since_prev + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_q    <= STB_HIGH;
      word_count <= '0;
    end else if (fire) begin
      level_q    <= (level_q == STB_HIGH) ? STB_LOW : STB_HIGH;
      word_count <= word_count + 1'b1;
    end
  end

  assign bus_strobe = level_q;
  assign space_ok   = (since_last >= W'(T_CYC)) && (since_prev >= W'(T_PAIR));
  assign hold_ok    = since_last >= W'(T_HOLD);
endmodule

// File: rtl/sbt_burst_tx.sv
module sbt_burst_tx
  import sbt_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned T_SETUP = 2,
  parameter int unsigned T_HOLD  = 1,
  parameter int unsigned T_CYC   = 2,
  parameter int unsigned T_PAIR  = 2 * T_CYC,
  parameter int unsigned T_START = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              host_rdy,
  input  logic              host_stop,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_strobe,
  output logic [CNT_W-1:0]  word_count
);
  localparam int unsigned SAT = max2(max2(T_SETUP, T_HOLD), max2(T_CYC, T_PAIR));
  localparam int unsigned W   = cnt_width(SAT);

  if (T_SETUP < 1 || T_HOLD < 1 || T_CYC < 1 || T_START < 1) begin : g_bad_limit
    $error("sbt_burst_tx: timing limits must be at least one cycle");
  end
  if (T_PAIR < 2 * T_CYC) begin : g_bad_pair
    $error("sbt_burst_tx: same-polarity spacing below twice the edge spacing");
  end

  logic host_go;
  logic setup_ok;
  logic space_ok;
  logic hold_ok;
  logic fire;

  assign host_go = host_rdy && !host_stop;
  assign fire    = setup_ok && space_ok && host_go;

  sbt_word_stage #(
    .DATA_W (DATA_W),
    .T_SETUP(T_SETUP),
    .SAT    (SAT),
    .W      (W)
  ) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_data  (in_data),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .hold_ok  (hold_ok),
    .fire     (fire),
    .bus_data (bus_data),
    .setup_ok (setup_ok)
  );

  sbt_edge_pacer #(
    .T_CYC (T_CYC),
    .T_PAIR(T_PAIR),
    .T_HOLD(T_HOLD),
    .SAT   (SAT),
    .W     (W),
    .CNT_W (CNT_W)
  ) u_pacer (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (fire),
    .space_ok   (space_ok),
    .hold_ok    (hold_ok),
    .bus_strobe (bus_strobe),
    .word_count (word_count)
  );
endmodule

// File: rtl/sbt_burst_tx_chk.sv
module sbt_burst_tx_chk #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned T_SETUP = 2,
  parameter int unsigned T_HOLD  = 1,
  parameter int unsigned T_CYC   = 2,
  parameter int unsigned T_PAIR  = 4,
  parameter int unsigned T_START = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] in_data,
  input logic              in_valid,
  input logic              in_ready,
  input logic              host_rdy,
  input logic              host_stop,
  input logic [DATA_W-1:0] bus_data,
  input logic              bus_strobe,
  input logic [CNT_W-1:0]  word_count
);
  localparam logic [15:0] CAP = 16'hFFFF;

  logic              stb_d;
  logic [DATA_W-1:0] bus_d;
  logic [15:0]       bus_age, gap_last, gap_prev, wait_cnt;
  logic              seen_edge;
  logic              edge_now, bus_chg, go;

  assign edge_now = bus_strobe != stb_d;
  assign bus_chg  = bus_data != bus_d;
  assign go       = host_rdy && !host_stop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stb_d     <= 1'b1;
      bus_d     <= '0;
      bus_age   <= CAP;
      gap_last  <= CAP;
      gap_prev  <= CAP;
      wait_cnt  <= '0;
      seen_edge <= 1'b0;
    end else begin
      stb_d   <= bus_strobe;
      bus_d   <= bus_data;
      bus_age <= bus_chg ? 16'd1 : ((bus_age == CAP) ? CAP : bus_age + 16'd1);
      if (edge_now) begin
        gap_prev  <= (gap_last == CAP) ? CAP : gap_last + 16'd1;
        gap_last  <= 16'd1;
        seen_edge <= 1'b1;
      end else begin
        gap_last <= (gap_last == CAP) ? CAP : gap_last + 16'd1;
        gap_prev <= (gap_prev == CAP) ? CAP : gap_prev + 16'd1;
      end
      if (go && !in_ready && !seen_edge && !edge_now && bus_age >= 16'(T_SETUP))
        wait_cnt <= wait_cnt + 16'd1;
      else
        wait_cnt <= '0;
    end
  end

  AST_PAUSE_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> $stable(bus_strobe)); // R2
  AST_FIRST_EDGE_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_now && !seen_edge) |-> !bus_strobe); // R3
  AST_SETUP_MET: assert property (@(posedge clk) disable iff (!rst_n)
    edge_now |-> (bus_age >= 16'(T_SETUP))); // R4
  AST_EDGE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    edge_now |-> (gap_last >= 16'(T_CYC))); // R5
  AST_PAIR_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    edge_now |-> (gap_prev >= 16'(T_PAIR))); // R6
  AST_HOLD_MET: assert property (@(posedge clk) disable iff (!rst_n)
    bus_chg |-> (gap_last >= 16'(T_HOLD))); // R7
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    edge_now |-> (word_count == $past(word_count) + 1'b1)); // R8
  AST_COUNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_now |-> $stable(word_count)); // R8
  AST_ACCEPT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (bus_data == $past(in_data))); // R9
  AST_START_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    wait_cnt <= 16'(T_START)); // R10
endmodule

bind sbt_burst_tx sbt_burst_tx_chk #(
  .DATA_W (DATA_W),
  .CNT_W  (CNT_W),
  .T_SETUP(T_SETUP),
  .T_HOLD (T_HOLD),
  .T_CYC  (T_CYC),
  .T_PAIR (T_PAIR),
  .T_START(T_START)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_data   (in_data),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .host_rdy  (host_rdy),
  .host_stop (host_stop),
  .bus_data  (bus_data),
  .bus_strobe(bus_strobe),
  .word_count(word_count)
);

// File: tb/sbt_burst_tx_tb.sv
module sbt_burst_tx_tb;
  localparam int T_SETUP = 2;
  localparam int T_HOLD  = 1;
  localparam int T_CYC   = 2;
  localparam int T_PAIR  = 7;
  localparam int T_START = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] in_data = 16'hDEAD;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        host_rdy = 1'b0;
  logic        host_stop = 1'b1;
  logic [15:0] bus_data;
  logic        bus_strobe;
  logic [15:0] word_count;

  sbt_burst_tx #(
    .DATA_W(16), .CNT_W(16), .T_SETUP(T_SETUP), .T_HOLD(T_HOLD),
    .T_CYC(T_CYC), .T_PAIR(T_PAIR), .T_START(T_START)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .host_rdy(host_rdy), .host_stop(host_stop),
    .bus_data(bus_data), .bus_strobe(bus_strobe), .word_count(word_count)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int sent = 0;
  int edges = 0;
  logic [15:0] exp_q[$];
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Driver: offers one word, records it as expected once accepted.
  task automatic send(input logic [15:0] w, input int gap);
    in_valid = 1'b1;
    in_data  = w;
    while (!in_ready) begin
      @(posedge clk); #2;
    end
    exp_q.push_back(w);
    sent++;
    @(posedge clk); #2;
    if (gap > 0) begin
      in_valid = 1'b0;
      in_data  = 16'hDEAD;
      repeat (gap) begin @(posedge clk); #2; end
    end
  endtask

  task automatic idle_stream();
    in_valid = 1'b0;
    in_data  = 16'hDEAD;
  endtask

  // Monitor: pops one expected word per strobe transition and checks timing.
  logic        stb_s = 1'b1;
  logic [15:0] bus_s = 16'h0;
  logic        go_s = 1'b0;
  int last_bus = -1000;
  int last_edge = -1000;
  int prev_edge = -1000;

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (bus_strobe !== stb_s) begin
        logic [15:0] exp;
        edges++;
        check(go_s, "R2", "edge without permission", 0, 1);
        if (edges == 1) check(bus_strobe == 1'b0, "R3", "first edge polarity", bus_strobe, 0);
        check(cyc - last_bus >= T_SETUP, "R4", "setup cycles", cyc - last_bus, T_SETUP);
        if (last_edge > -1000)
          check(cyc - last_edge >= T_CYC, "R5", "edge gap", cyc - last_edge, T_CYC);
        if (prev_edge > -1000)
          check(cyc - prev_edge >= T_PAIR, "R6", "same-polarity gap", cyc - prev_edge, T_PAIR);
        if (exp_q.size() == 0) begin
          check(1'b0, "R11", "edge with no word queued", 1, 0);
        end else begin
          exp = exp_q.pop_front();
          check(bus_data == exp, "R8", "word at edge", bus_data, exp);
        end
        prev_edge = last_edge;
        last_edge = cyc;
      end
      if (bus_data !== bus_s) begin
        if (last_edge > -1000)
          check(cyc - last_edge >= T_HOLD, "R7", "hold cycles", cyc - last_edge, T_HOLD);
        last_bus = cyc;
      end
      stb_s = bus_strobe;
      bus_s = bus_data;
    end
    go_s = host_rdy && !host_stop;
  end

  always @(posedge clk) begin
    if (cyc > 20000) begin
      check(1'b0, "R8", "watchdog expired", cyc, 20000);
      finish_run();
    end
  end

  // Far end pauses in the middle of a back-to-back burst.
  task automatic host_pauses();
    logic s;
    repeat (20) begin @(posedge clk); #2; end
    host_rdy = 1'b0;
    s = bus_strobe;
    repeat (9) begin
      @(negedge clk);
      check(bus_strobe == s, "R2", "level while ready low", bus_strobe, s);
    end
    @(posedge clk); #2;
    host_rdy = 1'b1;
    repeat (13) begin @(posedge clk); #2; end
    host_stop = 1'b1;
    s = bus_strobe;
    repeat (6) begin
      @(negedge clk);
      check(bus_strobe == s, "R2", "level while stop high", bus_strobe, s);
    end
    @(posedge clk); #2;
    host_stop = 1'b0;
  endtask

  initial begin
    int t0;
    logic [15:0] hold_bus;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(bus_strobe == 1'b1, "R1", "strobe after reset", bus_strobe, 1);
    check(bus_data == 16'h0, "R1", "bus after reset", bus_data, 0);
    check(word_count == 16'h0, "R1", "count after reset", word_count, 0);
    check(in_ready == 1'b1, "R1", "ready after reset", in_ready, 1);

    // R3/R9: preload while the far end withholds permission
    @(posedge clk); #2;
    send(16'hA001, 1);
    repeat (8) begin @(posedge clk); #2; end
    check(bus_strobe == 1'b1, "R2", "no edge before permission", bus_strobe, 1);
    check(bus_data == 16'hA001, "R3", "word on bus before first edge", bus_data, 16'hA001);
    check(in_ready == 1'b0, "R9", "ready while word waits", in_ready, 0);

    // R10: start latency once permission arrives
    host_rdy  = 1'b1;
    host_stop = 1'b0;
    t0 = cyc;
    @(negedge clk);
    while (bus_strobe == 1'b1 && cyc - t0 < 10) @(negedge clk);
    check(cyc - t0 == 1, "R10", "start latency", cyc - t0, 1);
    check(cyc - t0 <= T_START, "R10", "start within limit", cyc - t0, T_START);
    @(posedge clk); #2;

    // Back-to-back burst with far-end pauses (R2, R5, R6, R7, R8)
    fork
      begin
        for (int i = 0; i < 24; i++) send(16'hB000 + 16'(i * 37), 0);
        idle_stream();
      end
      host_pauses();
    join

    // R11: starved stream with gaps of varying length
    for (int i = 0; i < 16; i++) send(16'hC100 + 16'(i * 91), (i % 4) * 3 + (i % 3));
    idle_stream();
    repeat (30) begin @(posedge clk); #2; end
    check(exp_q.size() == 0, "R11", "all words drained", exp_q.size(), 0);
    check(edges == sent, "R8", "edges equal words", edges, sent);
    check(int'(word_count) == sent, "R8", "word count", word_count, sent);

    // R9: junk on in_data with valid low leaves the bus untouched
    hold_bus = bus_data;
    in_valid = 1'b0;
    for (int i = 0; i < 6; i++) begin
      in_data = 16'h5A5A ^ 16'(i);
      @(posedge clk); #2;
    end
    check(bus_data == hold_bus, "R9", "bus with valid low", bus_data, hold_bus);
    check(in_ready == 1'b1, "R9", "ready when idle", in_ready, 1);
    check(int'(word_count) == sent, "R9", "count with valid low", word_count, sent);

    finish_run();
  end
endmodule